// File: doc/BRIEF.md
# SPI Master with Extended Phase

A single-slave serial peripheral interface master that shifts a run of bytes out of a shared byte buffer and writes the bytes it receives back into the same buffer locations. The host loads the buffer through a write port, presents a 32-bit control word, a clock divider and a byte count, and pulses start. The block then drives slave select low, clocks the bytes out most-significant bit first and raises done for one cycle when the frame is over. Afterwards the host reads the received bytes through a read port.

Besides the four usual polarity and phase modes, an extended-phase option puts the data launch and the sample on the same serial-clock edge. On that edge the sample takes the line value from just before the edge, and the launch changes the line right after it. The serial clock can be held at its idle level while slave select is high, or left running at the divided rate. When the control word is not marked valid, a built-in default mode is used, so an explicit all-zero setting is not confused with "use defaults".

Top module: `spi_xphase_master`

## Requirements
- R1: While slave select is high and clock gating is enabled, sclk_o stays at the polarity level and shows no edges. Before a frame's first edge, sclk_o sits at the polarity level: 0 for polarity 0, 1 for polarity 1.
- R2: With gating disabled, sclk_o toggles every div_i+1 system cycles while the block is idle.
- R3: The edge after the idle level is the leading edge, rising for polarity 0 and falling for polarity 1. With extended-phase 0, phase 0 samples on leading edges and launches on trailing edges. Phase 1 launches on leading edges and samples on trailing edges.
- R4: With extended-phase 1, launch and sample fall on the same edge: leading edges for phase 0 and trailing edges for phase 1. The sample takes the line value from just before the edge, so each received bit is the one launched on the previous such edge.
- R5: Control word fields: bit 31 is config-valid, bit 30 is extended-phase, bit 29 is gate-when-deselected, bit 28 is polarity and bit 26 is phase. Bit 27 (clock-domain select) is accepted and has no effect.
- R6: When bit 31 is 0, all other control bits are ignored and the default mode is used: polarity 1, phase 1, extended-phase 0, gating on.
- R7: A frame of N bytes has exactly 16*N sclk edges, one half-period of div_i+1 system cycles apart. Bits go out on mosi_o most-significant first, starting with buffer byte 0.
- R8: ss_no falls on the cycle the start is accepted and busy_o rises with it. The first sclk edge comes div_i+1 cycles later. ss_no rises div_i+1 cycles after the last edge. On that same cycle busy_o falls and done_o is high for exactly one cycle.
- R9: Each received byte k replaces buffer byte k, and the host can read it through buf_raddr_i/buf_rdata_o after done_o.
- R10: A start with len_i of 0 or above 512 starts no frame. err_o pulses for one cycle, and busy_o and ss_no do not change. A length of exactly 512 is accepted.
- R11: A start pulse that arrives while busy_o is high is ignored. The running frame keeps its length and timing, and no second done_o or err_o follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctrl_i | input | 32 | Control word (fields in R5) |
| div_i | input | 8 | Half-period of sclk, minus one, in system cycles |
| len_i | input | 10 | Frame length in bytes |
| start_i | input | 1 | Start request, one cycle |
| buf_we_i | input | 1 | Host buffer write enable (ignored while busy) |
| buf_waddr_i | input | 9 | Host write byte address |
| buf_wdata_i | input | 8 | Host write data |
| buf_raddr_i | input | 9 | Host read byte address |
| buf_rdata_o | output | 8 | Host read data (combinational) |
| busy_o | output | 1 | Frame in progress |
| done_o | output | 1 | One-cycle pulse at frame end |
| err_o | output | 1 | One-cycle pulse on a rejected length |
| sclk_o | output | 1 | Serial clock |
| ss_no | output | 1 | Slave select, active low |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |

## Verification
The bench acts as a slave that sends its own byte pattern and checks the edge direction of every sclk transition. It runs all eight polarity, phase and extended-phase combinations. A design that put the extended-phase sample after the launch would receive every bit one position early, and a design that swapped the leading and trailing edge would show a wrong direction or a corrupted byte. The bench also checks the lead-in and tail half-periods and the total edge count, which catches an off-by-one in the half-period counter. It tests the 0, 513 and 512 length boundaries, a start during a frame, and the default mode with every other control bit set, where a design that honoured those bits would switch to extended-phase and corrupt the data.

// File: rtl/spi_xp_pkg.sv
package spi_xp_pkg;
  localparam int CW_VALID = 31;
  localparam int CW_XPH   = 30;
  localparam int CW_GATE  = 29;
  localparam int CW_POL   = 28;
  localparam int CW_PHA   = 26;

  typedef struct packed {
    logic pol;
    logic pha;
    logic xph;
    logic gate;
  } spi_cfg_t;

  localparam spi_cfg_t CFG_DEFAULT = '{pol: 1'b1, pha: 1'b1, xph: 1'b0, gate: 1'b1};

  function automatic spi_cfg_t cfg_decode(input logic [31:0] w);
    spi_cfg_t c;
    if (w[CW_VALID]) begin
      c.pol  = w[CW_POL];
      c.pha  = w[CW_PHA];
      c.xph  = w[CW_XPH];
      c.gate = w[CW_GATE];
    end else begin
      c = CFG_DEFAULT;
    end
    return c;
  endfunction
endpackage

// File: rtl/spi_xp_buf.sv
module spi_xp_buf #(
  parameter int DEPTH = 512,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_waddr_i,
  input  logic [DW-1:0] host_wdata_i,
  input  logic [AW-1:0] host_raddr_i,
  output logic [DW-1:0] host_rdata_o,
  input  logic          rx_we_i,
  input  logic [AW-1:0] rx_waddr_i,
  input  logic [DW-1:0] rx_wdata_i,
  input  logic [AW-1:0] tx_raddr_i,
  output logic [DW-1:0] tx_rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  // shift-side write wins; host writes are blocked while busy anyway
  always_ff @(posedge clk_i) begin
    if (rx_we_i) mem_q[rx_waddr_i] <= rx_wdata_i;
    else if (host_we_i) mem_q[host_waddr_i] <= host_wdata_i;
  end

  assign host_rdata_o = mem_q[host_raddr_i];
  assign tx_rdata_o   = mem_q[tx_raddr_i];
endmodule

// File: rtl/spi_xp_clkgen.sv
module spi_xp_clkgen #(
  parameter int DIVW = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [DIVW-1:0] div_i,
  input  logic            run_i,
  input  logic            restart_i,
  input  logic            hold_i,
  input  logic            lvl_i,
  input  logic            toggle_en_i,
  output logic            tick_o,
  output logic            sclk_o
);
  logic [DIVW-1:0] cnt_q;
  logic            sclk_q;

  assign tick_o = run_i && !restart_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b0;
    end else begin
      if (restart_i || !run_i || tick_o) cnt_q <= '0;
      else cnt_q <= cnt_q + 1'b1;

      if (restart_i || hold_i) sclk_q <= lvl_i;
      else if (tick_o && toggle_en_i) sclk_q <= ~sclk_q;
    end
  end

  assign sclk_o = sclk_q;
endmodule

// File: rtl/spi_xp_ctrl.sv
module spi_xp_ctrl
  import spi_xp_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DIVW  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LENW = AW + 1,
  localparam int BITW = AW + 4,
  localparam int EW   = AW + 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     ctrl_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [LENW-1:0] len_i,
  input  logic            start_i,
  input  logic            miso_i,
  input  logic            tick_i,
  input  logic [7:0]      tx_rdata_i,
  output logic [AW-1:0]   tx_raddr_o,
  output logic            rx_we_o,
  output logic [AW-1:0]   rx_waddr_o,
  output logic [7:0]      rx_wdata_o,
  output logic [DIVW-1:0] ck_div_o,
  output logic            ck_run_o,
  output logic            ck_restart_o,
  output logic            ck_hold_o,
  output logic            ck_lvl_o,
  output logic            ck_toggle_en_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            ss_no,
  output logic            mosi_o
);
  spi_cfg_t        live_c, cfg_q;
  logic            busy_q, done_q, err_q, ss_q, mosi_q;
  logic [DIVW-1:0] div_q;
  logic [LENW-1:0] nbytes_q;
  logic [EW-1:0]   total_q, edge_q;
  logic [7:0]      rx_sh_q;

  logic            len_ok, accept, edge_fire, finish, smp, lch;
  logic [BITW-1:0] bit_idx, launch_idx, nbits;

  assign live_c  = cfg_decode(ctrl_i);
  assign len_ok  = (len_i != '0) && (len_i <= LENW'(DEPTH));
  assign accept  = start_i && !busy_q && len_ok;

  assign finish    = busy_q && tick_i && (edge_q == total_q);
  assign edge_fire = busy_q && tick_i && (edge_q != total_q);
  assign bit_idx   = edge_q[EW-1:1];
  // even edge index = leading edge; sampling sits on leading edges iff phase is 0
  assign smp        = (edge_q[0] == cfg_q.pha);
  assign lch        = cfg_q.xph ? smp : !smp;
  assign launch_idx = (cfg_q.pha && !cfg_q.xph) ? bit_idx : bit_idx + 1'b1;
  assign nbits      = {nbytes_q, 3'b000};

  assign tx_raddr_o = accept ? '0 : launch_idx[AW+2:3];
  assign rx_we_o    = edge_fire && smp && (bit_idx[2:0] == 3'd7);
  assign rx_waddr_o = bit_idx[AW+2:3];
  assign rx_wdata_o = {rx_sh_q[6:0], miso_i};

  assign ck_div_o       = busy_q ? div_q : div_i;
  assign ck_run_o       = busy_q || !live_c.gate;
  assign ck_restart_o   = accept;
  assign ck_hold_o      = !busy_q && live_c.gate && !accept;
  assign ck_lvl_o       = busy_q ? cfg_q.pol : live_c.pol;
  assign ck_toggle_en_o = busy_q ? (edge_q != total_q) : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      ss_q     <= 1'b1;
      mosi_q   <= 1'b0;
      cfg_q    <= CFG_DEFAULT;
      div_q    <= '0;
      nbytes_q <= '0;
      total_q  <= '0;
      edge_q   <= '0;
      rx_sh_q  <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= start_i && !busy_q && !len_ok;
      if (accept) begin
        busy_q   <= 1'b1;
        ss_q     <= 1'b0;
        cfg_q    <= live_c;
        div_q    <= div_i;
        nbytes_q <= len_i;
        total_q  <= {len_i, 4'b0000};
        edge_q   <= '0;
        mosi_q   <= tx_rdata_i[7];
      end else if (finish) begin
        busy_q <= 1'b0;
        ss_q   <= 1'b1;
        done_q <= 1'b1;
      end else if (edge_fire) begin
        edge_q <= edge_q + 1'b1;
        if (smp) rx_sh_q <= {rx_sh_q[6:0], miso_i};
        if (lch && (launch_idx < nbits)) mosi_q <= tx_rdata_i[~launch_idx[2:0]];
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign err_o  = err_q;
  assign ss_no  = ss_q;
  assign mosi_o = mosi_q;

  // R8
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R8
  done_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && ss_no));
  // R10
  err_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (!busy_o && ss_no && !done_o));
  // R11
  select_from_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ss_no) |-> ($past(!busy_o) && $past(start_i)));
  // R7
  edge_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (edge_q <= total_q));
endmodule

// File: rtl/spi_xphase_master.sv
module spi_xphase_master
  import spi_xp_pkg::*;
#(
  parameter int DEPTH = 512,
  parameter int DIVW  = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LENW = AW + 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [31:0]     ctrl_i,
  input  logic [DIVW-1:0] div_i,
  input  logic [LENW-1:0] len_i,
  input  logic            start_i,
  input  logic            buf_we_i,
  input  logic [AW-1:0]   buf_waddr_i,
  input  logic [7:0]      buf_wdata_i,
  input  logic [AW-1:0]   buf_raddr_i,
  output logic [7:0]      buf_rdata_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            err_o,
  output logic            sclk_o,
  output logic            ss_no,
  output logic            mosi_o,
  input  logic            miso_i
);
  logic [AW-1:0]   tx_raddr, rx_waddr;
  logic [7:0]      tx_rdata, rx_wdata;
  logic            rx_we, tick;
  logic [DIVW-1:0] ck_div;
  logic            ck_run, ck_restart, ck_hold, ck_lvl, ck_toggle_en;
  spi_cfg_t        live_c;

  assign live_c = cfg_decode(ctrl_i);

  spi_xp_buf #(.DEPTH(DEPTH), .DW(8)) buf_i (
    .clk_i        (clk_i),
    .host_we_i    (buf_we_i && !busy_o),
    .host_waddr_i (buf_waddr_i),
    .host_wdata_i (buf_wdata_i),
    .host_raddr_i (buf_raddr_i),
    .host_rdata_o (buf_rdata_o),
    .rx_we_i      (rx_we),
    .rx_waddr_i   (rx_waddr),
    .rx_wdata_i   (rx_wdata),
    .tx_raddr_i   (tx_raddr),
    .tx_rdata_o   (tx_rdata)
  );

  spi_xp_clkgen #(.DIVW(DIVW)) clkgen_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .div_i       (ck_div),
    .run_i       (ck_run),
    .restart_i   (ck_restart),
    .hold_i      (ck_hold),
    .lvl_i       (ck_lvl),
    .toggle_en_i (ck_toggle_en),
    .tick_o      (tick),
    .sclk_o      (sclk_o)
  );

  spi_xp_ctrl #(.DEPTH(DEPTH), .DIVW(DIVW)) ctrl_i_u (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_i         (ctrl_i),
    .div_i          (div_i),
    .len_i          (len_i),
    .start_i        (start_i),
    .miso_i         (miso_i),
    .tick_i         (tick),
    .tx_rdata_i     (tx_rdata),
    .tx_raddr_o     (tx_raddr),
    .rx_we_o        (rx_we),
    .rx_waddr_o     (rx_waddr),
    .rx_wdata_o     (rx_wdata),
    .ck_div_o       (ck_div),
    .ck_run_o       (ck_run),
    .ck_restart_o   (ck_restart),
    .ck_hold_o      (ck_hold),
    .ck_lvl_o       (ck_lvl),
    .ck_toggle_en_o (ck_toggle_en),
    .busy_o         (busy_o),
    .done_o         (done_o),
    .err_o          (err_o),
    .ss_no          (ss_no),
    .mosi_o         (mosi_o)
  );

  // R1
  gated_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(!busy_o && live_c.gate)) |-> (sclk_o == $past(live_c.pol)));
  // R8
  select_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !ss_no);
endmodule

// File: tb/spi_xphase_master_tb_top.sv
module spi_xphase_master_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [31:0] ctrl = '0;
  logic [7:0] div = '0;
  logic [9:0] len = '0;
  logic       start = 1'b0;
  logic       we = 1'b0;
  logic [8:0] waddr = '0, raddr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy, done, err, sclk, ss_n, mosi;
  logic       miso = 1'b0;

  int n_tests = 0;
  int n_fail  = 0;

  always #4 clk = ~clk;

  spi_xphase_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ctrl_i(ctrl), .div_i(div), .len_i(len),
    .start_i(start), .buf_we_i(we), .buf_waddr_i(waddr), .buf_wdata_i(wdata),
    .buf_raddr_i(raddr), .buf_rdata_o(rdata), .busy_o(busy), .done_o(done),
    .err_o(err), .sclk_o(sclk), .ss_no(ss_n), .mosi_o(mosi), .miso_i(miso)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cw(input bit v, input bit x, input bit g,
                                     input bit p, input bit h, input bit a);
    return {v, x, g, p, a, h, 26'd0};
  endfunction

  // slave model and scoreboard state
  logic [7:0] exp_q[$];
  logic [7:0] slave_tx [512];
  bit m_pol, m_pha, m_xph;
  int m_n;
  int edges, lead_cyc, low_cyc, dir_err, idle_err;
  logic [7:0] cap;

  initial begin
    logic prev_ss, prev_sclk, prev_mosi;
    prev_ss = 1'b1; prev_sclk = 1'b0; prev_mosi = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && !ss_n) begin
        if (prev_ss) begin
          edges = 0; low_cyc = 0; dir_err = 0; cap = '0; lead_cyc = -1;
          idle_err = (sclk !== m_pol) ? 1 : 0;
          miso = slave_tx[0][7];
        end else if (sclk !== prev_sclk) begin
          int k, b, li;
          bit lead, smp, lch;
          k = edges; lead = (k % 2 == 0); b = k / 2;
          if (sclk !== (lead ^ m_pol)) dir_err++;
          if (k == 0) lead_cyc = low_cyc;
          smp = ((k % 2) == int'(m_pha));
          lch = m_xph ? smp : !smp;
          if (smp) begin
            cap = {cap[6:0], prev_mosi};
            if (b % 8 == 7) begin
              logic [7:0] e;
              if (exp_q.size() == 0) chk(1'b0, "R7 unexpected byte", cap, -1);
              else begin
                e = exp_q.pop_front();
                chk(cap == e, "R7 mosi byte", cap, e);
              end
            end
          end
          if (lch) begin
            li = (m_pha && !m_xph) ? b : b + 1;
            if (li < 8 * m_n) miso = slave_tx[li / 8][7 - li % 8];
          end
          edges++;
        end
        low_cyc++;
      end
      prev_ss = ss_n; prev_sclk = sclk; prev_mosi = mosi;
    end
  end

  task automatic run_xfer(input bit v, input bit x, input bit g, input bit p,
                          input bit h, input bit a, input int d, input int n,
                          input int seed, input bit inject, input string lbl);
    int cyc;
    if (v) begin m_pol = p; m_pha = h; m_xph = x; end
    else begin m_pol = 1; m_pha = 1; m_xph = 0; end
    m_n = n;
    exp_q.delete();
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      we = 1'b1; waddr = 9'(i); wdata = 8'((i * 37 + seed) & 255);
      exp_q.push_back(8'((i * 37 + seed) & 255));
      slave_tx[i] = 8'(((i * 91) ^ seed ^ 8'h5a) & 255);
    end
    @(negedge clk);
    we = 1'b0;
    ctrl = cw(v, x, g, p, h, a); div = 8'(d); len = 10'(n);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy && !ss_n, {lbl, " R8 busy and select at accept"}, {busy, ss_n}, 2);
    if (inject) begin
      repeat (5) @(negedge clk);
      len = 10'd2; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 60000) begin @(negedge clk); cyc++; end
    chk(done && !busy && ss_n, {lbl, " R8 done with busy low"}, {done, busy, ss_n}, 5);
    @(negedge clk);
    chk(!done, {lbl, " R8 done width"}, done, 0);
    chk(exp_q.size() == 0, {lbl, " R7 all bytes seen"}, exp_q.size(), 0);
    chk(edges == 16 * n, {lbl, " R7 edge count"}, edges, 16 * n);
    chk(lead_cyc == d + 1, {lbl, " R8 lead-in"}, lead_cyc, d + 1);
    chk(low_cyc == (d + 1) * (16 * n + 1), {lbl, " R8 select low cycles"}, low_cyc, (d + 1) * (16 * n + 1));
    chk(idle_err == 0, {lbl, " R1 level before first edge"}, idle_err, 0);
    chk(dir_err == 0, {lbl, m_xph ? " R4 edge direction" : " R3 edge direction"}, dir_err, 0);
    begin
      int bad;
      bad = 0;
      for (int i = 0; i < n; i++) begin
        raddr = 9'(i);
        #1;
        if (rdata !== slave_tx[i]) begin
          if (bad == 0) chk(1'b0, {lbl, " R9 readback"}, rdata, slave_tx[i]);
          bad++;
        end
      end
      if (bad == 0) chk(1'b1, {lbl, " R9 readback"}, 0, 0);
    end
    if (inject) begin
      int extra;
      extra = 0;
      repeat (40) begin
        @(negedge clk);
        if (done || busy || err || !ss_n) extra++;
      end
      chk(extra == 0, "R11 start while busy ignored", extra, 0);
    end
  endtask

  task automatic err_case(input int l);
    @(negedge clk);
    ctrl = cw(1, 0, 1, 0, 0, 0); len = 10'(l); div = 8'd0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err && !busy && ss_n, "R10 rejected length", {err, busy, ss_n}, 5);
    @(negedge clk);
    chk(!err && !busy && ss_n, "R10 no frame after reject", {err, busy, ss_n}, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && ss_n && !done && !err, "R8 reset outputs", {busy, ss_n, done, err}, 4);
    chk(sclk == 1'b1, "R6 default idle level", sclk, 1);

    // R2: free-running idle clock, div 2
    begin
      int tog;
      logic ps;
      ctrl = cw(1, 0, 0, 0, 0, 0); div = 8'd2;
      repeat (4) @(negedge clk);
      ps = sclk; tog = 0;
      repeat (30) begin @(negedge clk); if (sclk !== ps) tog++; ps = sclk; end
      chk(tog == 10, "R2 ungated idle toggles", tog, 10);
      ctrl = cw(1, 0, 1, 0, 0, 0);
      repeat (2) @(negedge clk);
      ps = sclk; tog = 0;
      repeat (20) begin @(negedge clk); if (sclk !== ps) tog++; ps = sclk; end
      chk(tog == 0 && sclk == 1'b0, "R1 gated idle hold", tog, 0);
    end

    err_case(0);
    err_case(513);

    for (int p = 0; p < 2; p++)
      for (int h = 0; h < 2; h++)
        for (int x = 0; x < 2; x++)
          run_xfer(1, x[0], 1, p[0], h[0], 0, (p + h + x) % 3, 1 + x + h,
                   p * 8 + h * 4 + x * 2 + 17, 0, x ? "R4 mode" : "R3 mode");

    run_xfer(1, 1, 0, 0, 1, 1, 1, 2, 99, 0, "R5 async bit ungated");
    run_xfer(0, 1, 1, 1, 1, 0, 0, 2, 55, 0, "R6 default mode");
    run_xfer(1, 0, 1, 0, 0, 0, 0, 3, 71, 1, "R11 inject");
    run_xfer(1, 1, 1, 1, 0, 0, 0, 512, 3, 0, "R10 max length");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule